// File: doc/BRIEF.md
# Dual-Channel Programmable-Length Compensation FIR

This block is a compensation FIR filter shared by two interleaved sample streams, channel A and channel B. Each input sample is 18 bits, signed, and carries a channel bit. The sample goes into the history of its own channel. The block then convolves that history with one coefficient set that both channels share. The filter length is programmable from 2 to 64 taps in steps of two. The result is scaled by one of two powers of two, rounded half-up and saturated to a signed 18-bit output that carries the same channel bit.

Coefficients are 18 bits wide and are written through a register-style port in two parts. A small part holds the two least significant bits and a large part holds the sixteen upper bits. A low-part write only stages its bits. The coefficient changes when the upper part for the same address is written, and it then uses the staged low bits. The block uses one time-shared multiplier and performs one multiply-accumulate per clock. A new sample is accepted only when the block reports that it is ready.

Top module: `cfir2ch_top`

## Requirements
- R1: A write with `cw_en`=1 and `cw_hi`=1 sets the coefficient at address {`cw_page`,`cw_addr`} (page bit is the address MSB, 64 addresses) to the signed 18-bit value {`cw_data`[15:0], staged low bits}, where the staged low bits are those last written to that address.
- R2: A write with `cw_en`=1 and `cw_hi`=0 stores `cw_data`[1:0] as staged low bits for its address and leaves the active coefficient, and so the filter output, unchanged.
- R3: With `tap_sel`=N taken when a sample is accepted, the output is the sum over k = 0 .. 2(N+1)-1 of coef[k] × history[k]. Here history[0] is the newest sample of the channel. Coefficients at higher addresses have no effect, and later changes of `tap_sel` have no effect on that result.
- R4: Each channel (`in_ch` 0 = A, 1 = B) keeps its own history of up to 64 samples. A sample enters only the history of its own channel and the convolution reads only that history.
- R5: Both channels are filtered with the same coefficient set.
- R6: The sum is scaled by 2^-19 when `gain_sel` is 0 and by 2^-18 when it is 1. The value is taken when the sample is accepted.
- R7: Scaling rounds half-up: an exact half goes toward plus infinity (1.5 gives 2, -1.5 gives -1).
- R8: A scaled result beyond the signed 18-bit range is clamped to 131071 or -131072.
- R9: `in_ready` is high exactly when the block is idle. After a sample is accepted, `in_ready` drops on the next cycle. `out_valid` is a one-cycle pulse that arrives 2(N+1) clock edges after the accepting edge.
- R10: After reset, `in_ready` is 1, `out_valid` is 0, and all coefficients and histories are zero.
- R11: `out_ch` equals the channel bit of the sample whose result is on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_en | input | 1 | Coefficient write strobe |
| cw_hi | input | 1 | 1 = upper part (commits), 0 = low part (staged) |
| cw_page | input | 1 | Upper address bit of the coefficient write |
| cw_addr | input | 5 | Lower address bits of the coefficient write |
| cw_data | input | 16 | Write data; low part uses bits [1:0] |
| tap_sel | input | 5 | N, giving 2(N+1) active taps |
| gain_sel | input | 1 | Output scale select |
| in_valid | input | 1 | Input sample present |
| in_ch | input | 1 | Input channel, 0 = A, 1 = B |
| in_data | input | 18 | Signed input sample |
| in_ready | output | 1 | Block can accept a sample |
| out_valid | output | 1 | Output sample present (one cycle) |
| out_ch | output | 1 | Channel of the output sample |
| out_data | output | 18 | Signed, rounded and saturated output |

## Verification
The bench uses the default parameters: 18-bit data and coefficients, 64 coefficient addresses and a base shift of 19. This covers the full 64-tap length, both pages of the write address, and the shortest 2-tap filter in one build. Because the accumulator is wide, a run of full-scale samples against full-scale coefficients drives the scaled sum past both 18-bit limits. Short filters with one nonzero coefficient place an exact half at both signs for the rounding check.

// File: rtl/cfir2ch_pkg.sv
`timescale 1ns/1ps
package cfir2ch_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MAC  = 1'b1
    } fir_state_e;
endpackage

// File: rtl/cfir2ch_coef_bank.sv
`timescale 1ns/1ps
// Split-write coefficient store: low bits are staged, the upper write commits.
module cfir2ch_coef_bank #(
    parameter int COEF_W = 18,
    parameter int LO_W   = 2,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int HI_W   = COEF_W - LO_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_hi,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [HI_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [COEF_W-1:0] rd_coef
);
    typedef struct packed {
        logic [DEPTH-1:0][LO_W-1:0]   lo;
        logic [DEPTH-1:0][COEF_W-1:0] coef;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (wr_hi) begin
                bank_d.coef[wr_addr] = {wr_data, bank_q.lo[wr_addr]};
            end else begin
                bank_d.lo[wr_addr] = wr_data[LO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_coef = bank_q.coef[rd_addr];
endmodule

// File: rtl/cfir2ch_hist.sv
`timescale 1ns/1ps
// Per-channel sample histories; index 0 is the newest sample.
module cfir2ch_hist #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 64,
    parameter int NCH    = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CH_W-1:0]   push_ch,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_sample
);
    typedef logic [DEPTH-1:0][DATA_W-1:0] line_t;

    logic [DATA_W-1:0] tap_of [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (push && (push_ch == CH_W'(c))) begin
                for (int k = DEPTH - 1; k > 0; k--) begin
                    line_d[k] = line_q[k-1];
                end
                line_d[0] = push_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= '0;
            end else begin
                line_q <= line_d;
            end
        end

        assign tap_of[c] = line_q[rd_idx];
    end

    assign rd_sample = tap_of[rd_ch];
endmodule

// File: rtl/cfir2ch_scale.sv
`timescale 1ns/1ps
// Power-of-two scaling with half-up rounding and saturation.
module cfir2ch_scale #(
    parameter int ACC_W   = 42,
    parameter int DATA_W  = 18,
    parameter int SH_BASE = 19
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic                    gain,
    output logic [DATA_W-1:0]       y
);
    localparam int SH0 = SH_BASE;
    localparam int SH1 = SH_BASE - 1;
    localparam logic signed [ACC_W:0] HALF0 = (ACC_W+1)'(1) << (SH0 - 1);
    localparam logic signed [ACC_W:0] HALF1 = (ACC_W+1)'(1) << (SH1 - 1);
    localparam logic signed [ACC_W:0] MAXV  = (ACC_W+1)'((64'd1 << (DATA_W - 1)) - 64'd1);
    localparam logic signed [ACC_W:0] MINV  = -MAXV - (ACC_W+1)'(1);

    logic signed [ACC_W:0] wide;
    logic signed [ACC_W:0] shifted;

    always_comb begin
        wide = {acc[ACC_W-1], acc};
        if (gain) begin
            shifted = (wide + HALF1) >>> SH1;
        end else begin
            shifted = (wide + HALF0) >>> SH0;
        end
        if (shifted > MAXV) begin
            y = MAXV[DATA_W-1:0];
        end else if (shifted < MINV) begin
            y = MINV[DATA_W-1:0];
        end else begin
            y = shifted[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/cfir2ch_top.sv
`timescale 1ns/1ps
// Two-channel compensation FIR with one serial multiply-accumulate.
module cfir2ch_top
    import cfir2ch_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int COEF_W  = 18,
    parameter int LO_W    = 2,
    parameter int DEPTH   = 64,
    parameter int SH_BASE = 19,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int NSEL_W = ADDR_W - 1,
    localparam int HI_W   = COEF_W - LO_W,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int ACC_W  = PROD_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_en,
    input  logic              cw_hi,
    input  logic              cw_page,
    input  logic [NSEL_W-1:0] cw_addr,
    input  logic [HI_W-1:0]   cw_data,
    input  logic [NSEL_W-1:0] tap_sel,
    input  logic              gain_sel,
    input  logic              in_valid,
    input  logic              in_ch,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_ch,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        fir_state_e              st;
        logic [ADDR_W-1:0]       idx;
        logic [ADDR_W-1:0]       last;
        logic                    gain;
        logic                    ch;
        logic signed [ACC_W-1:0] acc;
        logic                    ov;
        logic                    och;
        logic [DATA_W-1:0]       od;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, default: '0};

    ctl_t ctl_d, ctl_q;

    logic                     accept;
    logic [DATA_W-1:0]        tap_sample;
    logic signed [COEF_W-1:0] tap_coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_sum;
    logic [DATA_W-1:0]        scaled;

    assign accept = in_valid && (ctl_q.st == ST_IDLE);

    cfir2ch_coef_bank #(
        .COEF_W (COEF_W),
        .LO_W   (LO_W),
        .DEPTH  (DEPTH)
    ) i_coef_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_hi   (cw_hi),
        .wr_addr ({cw_page, cw_addr}),
        .wr_data (cw_data),
        .rd_addr (ctl_q.idx),
        .rd_coef (tap_coef)
    );

    cfir2ch_hist #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .NCH    (2)
    ) i_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_ch   (in_ch),
        .push_data (in_data),
        .rd_ch     (ctl_q.ch),
        .rd_idx    (ctl_q.idx),
        .rd_sample (tap_sample)
    );

    assign prod    = $signed(tap_sample) * tap_coef;
    assign acc_sum = ctl_q.acc + ACC_W'(prod);

    cfir2ch_scale #(
        .ACC_W   (ACC_W),
        .DATA_W  (DATA_W),
        .SH_BASE (SH_BASE)
    ) i_scale (
        .acc  (acc_sum),
        .gain (ctl_q.gain),
        .y    (scaled)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.ov = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st   = ST_MAC;
                    ctl_d.idx  = '0;
                    ctl_d.last = {tap_sel, 1'b1};
                    ctl_d.gain = gain_sel;
                    ctl_d.ch   = in_ch;
                    ctl_d.acc  = '0;
                end
            end
            ST_MAC: begin
                ctl_d.acc = acc_sum;
                ctl_d.idx = ctl_q.idx + ADDR_W'(1);
                if (ctl_q.idx == ctl_q.last) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.ov  = 1'b1;
                    ctl_d.och = ctl_q.ch;
                    ctl_d.od  = scaled;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready  = (ctl_q.st == ST_IDLE);
    assign out_valid = ctl_q.ov;
    assign out_ch    = ctl_q.och;
    assign out_data  = ctl_q.od;
endmodule

// File: rtl/cfir2ch_chk.sv
`timescale 1ns/1ps
module cfir2ch_chk #(
    parameter int NSEL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSEL_W-1:0] tap_sel,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_ch,
    input logic              out_valid,
    input logic              out_ch
);
    localparam int CW = NSEL_W + 2;

    logic          busy;
    logic          acc_ch;
    logic [CW-1:0] cyc;
    logic [CW-1:0] exp_t;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            acc_ch <= 1'b0;
            cyc    <= '0;
            exp_t  <= '0;
        end else if (in_valid && in_ready) begin
            busy   <= 1'b1;
            acc_ch <= in_ch;
            cyc    <= '0;
            exp_t  <= CW'({tap_sel, 1'b0}) + CW'(2);
        end else begin
            if (busy) begin
                cyc <= cyc + CW'(1);
            end
            if (out_valid) begin
                busy <= 1'b0;
            end
        end
    end

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy && (cyc == exp_t)));

    // R11
    out_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ch == acc_ch));
endmodule

bind cfir2ch_top cfir2ch_chk #(.NSEL_W(NSEL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_sel   (tap_sel),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_ch     (in_ch),
    .out_valid (out_valid),
    .out_ch    (out_ch)
);

// File: tb/test_cfir2ch_top.sv
`timescale 1ns/1ps
module test_cfir2ch_top;
    localparam int DATA_W = 18;
    localparam int DEPTH  = 64;
    localparam int NSEL_W = 5;
    localparam int HI_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cw_en, cw_hi, cw_page;
    logic [NSEL_W-1:0] cw_addr;
    logic [HI_W-1:0]   cw_data;
    logic [NSEL_W-1:0] tap_sel;
    logic              gain_sel;
    logic              in_valid, in_ch;
    logic [DATA_W-1:0] in_data;
    logic              in_ready, out_valid, out_ch;
    logic [DATA_W-1:0] out_data;

    always #2.5 clk = ~clk;

    cfir2ch_top i_cfir2ch_top (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_hi(cw_hi), .cw_page(cw_page),
        .cw_addr(cw_addr), .cw_data(cw_data), .tap_sel(tap_sel), .gain_sel(gain_sel),
        .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint coef_m [DEPTH];
    int     lo_m   [DEPTH];
    longint hist_m [2][DEPTH];

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(bit hi, int a, int v);
        @(negedge clk);
        cw_en = 1'b1; cw_hi = hi; cw_page = a[5]; cw_addr = a[4:0]; cw_data = v[15:0];
        @(negedge clk);
        cw_en = 1'b0;
        if (hi) begin
            longint val = (longint'(v & 32'hFFFF) << 2) + longint'(lo_m[a]);
            if (val >= 131072) val -= 262144;
            coef_m[a] = val;
        end else begin
            lo_m[a] = v & 3;
        end
    endtask

    task automatic set_coef(int a, int c);
        wr(1'b0, a, c & 3);
        wr(1'b1, a, (c >>> 2) & 32'hFFFF);
    endtask

    function automatic longint model(int ch, int n, bit g);
        longint acc = 0;
        longint r;
        int     sh = g ? 18 : 19;
        for (int k = 0; k < 2 * (n + 1); k++) acc += coef_m[k] * hist_m[ch][k];
        r = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
        if (r > 131071) r = 131071;
        if (r < -131072) r = -131072;
        return r;
    endfunction

    task automatic run(string req, bit ch, int x, int n, bit g);
        longint exp;
        int     cyc = 0;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_ch = ch; in_data = x[17:0]; tap_sel = n[4:0]; gain_sel = g;
        @(posedge clk);
        for (int k = DEPTH - 1; k > 0; k--) hist_m[ch][k] = hist_m[ch][k-1];
        hist_m[ch][0] = longint'(x);
        exp = model(ch, n, g);
        @(negedge clk);
        in_valid = 1'b0;
        tap_sel  = NSEL_W'($urandom);   // R3/R6: later changes must not matter
        gain_sel = 1'($urandom);
        check("R9", "in_ready while busy", longint'(in_ready), 0);
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!out_valid && cyc < 200);
        check("R9", "latency", cyc, 2 * (n + 1));
        check("R11", "out_ch", longint'(out_ch), longint'(ch));
        check(req, "out_data", longint'($signed(out_data)), exp);
        @(negedge clk);
        check("R9", "pulse width", longint'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: got no completion, expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        foreach (coef_m[a]) begin coef_m[a] = 0; lo_m[a] = 0; end
        foreach (hist_m[c, k]) hist_m[c][k] = 0;
        rst_n = 1'b0; cw_en = 0; cw_hi = 0; cw_page = 0; cw_addr = '0; cw_data = '0;
        tap_sel = '0; gain_sel = 0; in_valid = 0; in_ch = 0; in_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "in_ready after reset", longint'(in_ready), 1);
        check("R10", "out_valid after reset", longint'(out_valid), 0);
        run("R10", 1'b0, 1000, 31, 1'b0);

        // R2: staged low bits alone change nothing
        wr(1'b0, 0, 3);
        run("R2", 1'b0, 5000, 0, 1'b0);
        // R1: upper write commits with staged low bits; page bit reaches upper half
        wr(1'b1, 0, 1);
        run("R1", 1'b0, 100000, 0, 1'b0);
        set_coef(33, -5000);
        set_coef(1, 3000);
        for (int i = 0; i < 4; i++) run("R1", 1'b0, 90000 - i * 50000, 16, 1'b0);

        // R3: taps beyond the active length are ignored
        set_coef(2, 40000);
        run("R3", 1'b0, -70000, 0, 1'b0);
        run("R3", 1'b0, 60000, 1, 1'b0);

        // R6: both gain settings
        run("R6", 1'b1, 120000, 3, 1'b0);
        run("R6", 1'b1, 120000, 3, 1'b1);

        // R7: exact halves at both signs
        for (int a = 0; a < DEPTH; a++) set_coef(a, 0);
        set_coef(0, 8);
        run("R7", 1'b0, 98304, 0, 1'b0);
        check("R7", "+1.5 rounds", longint'($signed(out_data)), 2);
        run("R7", 1'b0, -98304, 0, 1'b0);
        check("R7", "-1.5 rounds", longint'($signed(out_data)), -1);
        run("R7", 1'b0, 49152, 0, 1'b1);

        // R4/R5: separate histories, shared coefficients
        set_coef(1, 65536);
        run("R4", 1'b1, 70000, 0, 1'b0);
        run("R4", 1'b0, 10, 0, 1'b0);
        run("R4", 1'b0, 20, 0, 1'b0);
        run("R5", 1'b1, 5, 0, 1'b0);

        // R8: saturation at both limits
        for (int a = 0; a < DEPTH; a++) set_coef(a, 131071);
        for (int i = 0; i < 64; i++) run("R8", 1'b0, 131071, 31, 1'b0);
        check("R8", "upper clamp", longint'($signed(out_data)), 131071);
        for (int i = 0; i < 64; i++) run("R8", 1'b0, -131072, 31, 1'b1);
        check("R8", "lower clamp", longint'($signed(out_data)), -131072);

        // Random mix of channels, lengths, gains and coefficient updates
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                set_coef(int'($urandom_range(0, 63)), int'($urandom_range(0, 262143)) - 131072);
            end
            if ($urandom_range(0, 7) == 0) begin
                wr(1'b0, int'($urandom_range(0, 63)), int'($urandom_range(0, 3)));
            end
            run((i % 2) ? "R5" : "R4", 1'($urandom), int'($urandom_range(0, 262143)) - 131072,
                int'($urandom_range(0, 31)), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule